// File: doc/BRIEF.md
# SPI Page-Write Memory Command Engine

This block is the serial front end of a byte-wide nonvolatile memory. It listens as an SPI slave in clock mode 0 or mode 3, takes an 8-bit command after chip select falls, gathers a three-byte address, and then either streams array bytes out or collects bytes into a one-page buffer. All serial pins are brought into the system clock domain through two-flop synchronisers, and every SCK, chip select and hold edge is detected there.

A page write is committed when chip select rises cleanly on a byte boundary. The write-enable latch must be set, and the external protection unit must not refuse the page. A busy timer, counted in system clocks, then stands in for the self-timed programming cycle. During the first page-length cycles of that window the buffer is copied into the array, one byte per clock. Status writes go to the external status and protection unit through a one-cycle strobe. That unit returns the protect configuration bits and two deny flags.

Top module: `spi_nvm_cmd`

## Requirements
- R1: Command bytes are decoded only when bits 7..4 are zero. Bit 3 is ignored. Bits 2..0 select the command: 110 set write enable, 100 clear write enable, 101 status read, 001 status write, 011 array read, 010 page write.
- R2: Every byte moves most significant bit first. SI is sampled on rising SCK and SO changes on falling SCK, so the same sequence works whether SCK idles low (mode 0) or high (mode 3).
- R3: A command byte that matches no command locks the slave until the next chip-select falling edge. While locked, nothing is shifted in and SO stays at high impedance.
- R4: Read and write take three address bytes, sent high byte first. Only the low AW address bits are kept and all higher bits are discarded.
- R5: A read streams bytes for as long as chip select stays low. The full AW-bit address advances after each byte and wraps from the top address to 0.
- R6: A write fills a page buffer. Only the low PW address bits advance, and the page number stays fixed, so bytes beyond one page wrap and overwrite earlier bytes. On commit the page is copied into the array at {page, index}.
- R7: Chip select rising commits a write or status write only when all of these hold: it follows a complete byte with no SCK rising edge since, the write-enable latch is set, and the matching deny input is low. Otherwise the command is dropped, the block stays idle and the latch is unchanged.
- R8: While busy, status reads return 0xFF and every other command is ignored, with SO held at high impedance. The busy period lasts BUSY_CYC system clocks, and the write-enable latch clears when it ends.
- R9: Hold taken low while SCK is low freezes the sequence and floats SO. SCK and SI are ignored while held. Hold taken high while SCK is low resumes the transfer where it stopped.
- R10: With chip select high, SO is at high impedance and so_oe is 0. After reset the block is idle, not busy and not write enabled.
- R11: The status byte, when not busy, is {prot_cfg[2], 3'b000, prot_cfg[1], prot_cfg[0], write-enable latch, 0}.
- R12: A committed status write pulses sr_wr_stb for one clock with the received byte on sr_wr_data, and it starts the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out, high impedance when not driven |
| so_oe | output | 1 | SO drive enable |
| mem_addr | output | AW | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write enable |
| mem_rdata | input | 8 | Array read data, valid one clock after the address |
| prot_cfg | input | 3 | Protection configuration {enable, level[1:0]} shown in status |
| wr_deny | input | 1 | Protection unit refuses the page at wr_page |
| sr_deny | input | 1 | Protection unit refuses status writes |
| wr_page | output | AW | Base address of the page being collected |
| sr_wr_stb | output | 1 | One-cycle status write strobe |
| sr_wr_data | output | 8 | Status byte to be written |

## Verification
A wrong command or lock state shows up as SO driving during a sequence that should stay silent, or as a floating output where read data was due, within the first data byte. A wrong address or page counter shows up as the wrong bytes in the array after the busy period ends, or as wrong read data at a page or array wrap. A wrong commit or busy decision shows up in the next status read: a busy flag or write-enable bit that is wrong, or a status strobe that does not match. A wrong hold decision shows up as a shifted or floating bit once the transfer resumes.

// File: rtl/spi_nvm_cmd.sv
module spi_nvm_cmd #(
  parameter int AW       = 17,
  parameter int PW       = 7,
  parameter int BUSY_CYC = 50000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  output wire           so,
  output logic          so_oe,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  input  logic [7:0]    mem_rdata,
  input  logic [2:0]    prot_cfg,
  input  logic          wr_deny,
  input  logic          sr_deny,
  output logic [AW-1:0] wr_page,
  output logic          sr_wr_stb,
  output logic [7:0]    sr_wr_data
);
  localparam int PAGE = 1 << PW;
  localparam int TW   = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {S_OP, S_ADR, S_WD, S_RD, S_SR, S_SRIN, S_IGN, S_LOCK} st_t;

  logic [2:0] cs_p, sck_p, hold_p;
  logic [1:0] si_p;
  st_t        st;
  logic [2:0] bcnt, obit;
  logic [6:0] sh, osh;
  logic [1:0] acnt;
  logic       is_wr, armed, wel, busy, pgm, held, ovld, so_q;
  logic [AW-1:0]    addr;
  logic [PW-1:0]    widx;
  logic [AW-PW-1:0] pbase;
  logic [TW-1:0]    tmr;
  logic [7:0]       pbuf [PAGE];

  wire cs_s    = cs_p[1];
  wire cs_fall = cs_p[2] & ~cs_p[1];
  wire cs_rise = ~cs_p[2] & cs_p[1];
  wire rise    = ~sck_p[2] & sck_p[1];
  wire fall    = sck_p[2] & ~sck_p[1];
  wire go      = ~cs_s & ~held;

  wire [7:0]    rx_byte = {sh, si_p[1]};
  wire [AW-1:0] na      = AW'({addr, rx_byte});
  wire          op_ok   = (rx_byte[7:4] == 4'h0) &&
                          (rx_byte[2:0] inside {3'b110, 3'b100, 3'b101, 3'b001, 3'b011, 3'b010});
  wire          byte_done = go & rise & (bcnt == 3'd7);
  wire [7:0]    stat    = busy ? 8'hFF : {prot_cfg[2], 3'b000, prot_cfg[1:0], wel, 1'b0};
  wire [7:0]    src     = (st == S_RD) ? mem_rdata : stat;
  wire          outst   = (st == S_RD) || (st == S_SR);

  assign so_oe     = ~cs_n & ~cs_s & ~held & ovld & outst;
  assign so        = so_oe ? so_q : 1'bz;
  assign mem_we    = busy & pgm & (tmr < TW'(PAGE));
  assign mem_addr  = mem_we ? {pbase, tmr[PW-1:0]} : addr;
  assign mem_wdata = pbuf[tmr[PW-1:0]];
  assign wr_page   = {pbase, {PW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= 3'b111; sck_p <= 3'b000; hold_p <= 3'b111; si_p <= 2'b00;
    end else begin
      cs_p   <= {cs_p[1:0], cs_n};
      sck_p  <= {sck_p[1:0], sck};
      hold_p <= {hold_p[1:0], hold_n};
      si_p   <= {si_p[0], si};
    end
  end

  always_ff @(posedge clk)
    if (byte_done && st == S_WD) pbuf[widx] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IGN; bcnt <= '0; obit <= '0; sh <= '0; osh <= '0; acnt <= '0;
      is_wr <= 1'b0; armed <= 1'b0; wel <= 1'b0; busy <= 1'b0; pgm <= 1'b0;
      held <= 1'b0; ovld <= 1'b0; so_q <= 1'b0; addr <= '0; widx <= '0;
      pbase <= '0; tmr <= '0; sr_wr_stb <= 1'b0; sr_wr_data <= '0;
    end else begin
      sr_wr_stb <= 1'b0;
      if (cs_fall) begin
        st <= S_OP; bcnt <= '0; obit <= '0; held <= 1'b0; armed <= 1'b0; ovld <= 1'b0;
      end else if (cs_rise) begin
        st <= S_IGN; held <= 1'b0; ovld <= 1'b0;
        if (st == S_WD && armed && wel && !wr_deny) begin
          busy <= 1'b1; pgm <= 1'b1; tmr <= '0;
        end
        if (st == S_SRIN && armed && wel && !sr_deny) begin
          busy <= 1'b1; pgm <= 1'b0; tmr <= '0; sr_wr_stb <= 1'b1;
        end
      end else if (!cs_s) begin
        if (!held && hold_p[2] && !hold_p[1] && !sck_p[1]) held <= 1'b1;
        else if (held && !hold_p[2] && hold_p[1] && !sck_p[1]) held <= 1'b0;
        if (go && rise) begin
          bcnt  <= bcnt + 3'd1;
          sh    <= {sh[5:0], si_p[1]};
          armed <= 1'b0;
        end
        if (byte_done) begin
          case (st)
            S_OP: begin
              if (!op_ok) st <= S_LOCK;
              else if (busy && rx_byte[2:0] != 3'b101) st <= S_IGN;
              else begin
                case (rx_byte[2:0])
                  3'b110:  begin wel <= 1'b1; st <= S_IGN; end
                  3'b100:  begin wel <= 1'b0; st <= S_IGN; end
                  3'b101:  st <= S_SR;
                  3'b001:  st <= S_SRIN;
                  3'b011:  begin st <= S_ADR; is_wr <= 1'b0; acnt <= '0; end
                  default: begin st <= S_ADR; is_wr <= 1'b1; acnt <= '0; end
                endcase
              end
            end
            S_ADR: begin
              addr <= na;
              acnt <= acnt + 2'd1;
              if (acnt == 2'd2) begin
                st    <= is_wr ? S_WD : S_RD;
                widx  <= na[PW-1:0];
                pbase <= na[AW-1:PW];
              end
            end
            S_WD:   begin widx <= widx + 1'b1; armed <= 1'b1; end
            S_RD:   addr <= addr + 1'b1;
            S_SRIN: begin sr_wr_data <= rx_byte; armed <= 1'b1; end
            default: ;
          endcase
        end
        if (go && fall && outst) begin
          ovld <= 1'b1;
          obit <= obit + 3'd1;
          if (obit == 3'd0) begin
            so_q <= src[7]; osh <= src[6:0];
          end else begin
            so_q <= osh[6]; osh <= {osh[5:0], 1'b0};
          end
        end
      end
      if (busy) begin
        tmr <= tmr + 1'b1;
        if (tmr == TW'(BUSY_CYC - 1)) begin
          busy <= 1'b0; pgm <= 1'b0; wel <= 1'b0;
        end
      end
    end
  end

  p_lock_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK && !cs_fall) |=> (st == S_LOCK || st == S_IGN));

  p_wel_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  p_no_collect_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st != S_WD));

  p_held_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_fall && !cs_rise) |=> ($stable(bcnt) && $stable(so_q)));

  p_stb_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_stb |=> (!sr_wr_stb && busy));
endmodule

// File: tb/sim_spi_nvm_cmd.sv
module sim_spi_nvm_cmd;
  localparam int CLK_P = 10;
  localparam int H     = 8;
  localparam int AW    = 12;
  localparam int MEMN  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  wire  so;
  logic so_oe, mem_we, wr_deny = 1'b0, sr_deny = 1'b0, sr_wr_stb;
  logic [AW-1:0] mem_addr, wr_page;
  logic [7:0] mem_wdata, mem_rdata, sr_wr_data;
  logic [2:0] prot_cfg = 3'b101;
  logic [7:0] mem [MEMN];
  logic [7:0] exp_m [MEMN];
  int n_chk = 0, n_err = 0, stb_n = 0;
  logic [7:0] stb_d = '0;
  bit m3 = 1'b0, done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_nvm_cmd #(.AW(AW), .PW(7), .BUSY_CYC(2000)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .prot_cfg(prot_cfg), .wr_deny(wr_deny), .sr_deny(sr_deny),
    .wr_page(wr_page), .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (sr_wr_stb) begin stb_n <= stb_n + 1; stb_d <= sr_wr_data; end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_any);
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i]; tick(H);
      rx[i] = so;
      if (so_oe) oe_any = 1'b1;
      sck = 1'b1; tick(H);
    end
  endtask

  task automatic cs_on();
    sck = m3; tick(H);
    cs_n = 1'b0; tick(H);
  endtask

  task automatic cs_off();
    sck = m3; tick(H);
    cs_n = 1'b1; tick(H);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r; bit o;
    xfer(b, r, o);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_on(); send(op); cs_off();
  endtask

  task automatic rdsr(output logic [7:0] v);
    bit o;
    cs_on(); send(8'h05); xfer(8'h00, v, o); cs_off();
  endtask

  task automatic wait_ready();
    logic [7:0] v;
    for (int k = 0; k < 100; k++) begin
      rdsr(v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic rd_chk(input string tag, input logic [23:0] a, input int n);
    logic [7:0] r; bit o;
    cs_on(); send(8'h03); send(a[23:16]); send(a[15:8]); send(a[7:0]);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r, o);
      chk(tag, r, exp_m[AW'(a[AW-1:0] + AW'(k))]);
    end
    cs_off();
  endtask

  task automatic t_reset();
    chk("R10 so floats after reset", so, 1'bz);
    chk("R10 so_oe low after reset", so_oe, 1'b0);
    chk("R10 no array write after reset", mem_we, 1'b0);
  endtask

  task automatic t_status_wel();
    logic [7:0] v;
    rdsr(v); chk("R11 idle status", v, 8'h84);
    cmd1(8'h0E); rdsr(v); chk("R1 set-enable with bit3 set", v, 8'h86);
    cmd1(8'h04); rdsr(v); chk("R1 clear-enable", v, 8'h84);
    cmd1(8'h06); rdsr(v); chk("R1 set-enable", v, 8'h86);
    cmd1(8'h0C); rdsr(v); chk("R1 clear-enable with bit3 set", v, 8'h84);
  endtask

  task automatic t_page_write();
    logic [7:0] v, r; bit o;
    cmd1(8'h06);
    cs_on(); send(8'h02); send(8'hFE); send(8'h01); send(8'h90);
    chk("R4 r6_ page base ignores high bits", wr_page, 12'h180);
    for (int i = 0; i < 130; i++) begin
      send(8'(i * 37 + 5));
      exp_m[12'h180 + 12'((8'h10 + i) % 128)] = 8'(i * 37 + 5);
    end
    cs_off();
    rdsr(v); chk("R8 status while busy", v, 8'hFF);
    cs_on(); send(8'h03); send(8'h00); send(8'h01); send(8'h80);
    xfer(8'h00, r, o); chk("R8 read ignored while busy", o, 1'b0);
    cs_off();
    wait_ready();
    rdsr(v); chk("R8 enable cleared after cycle", v, 8'h84);
    rd_chk("R6 page contents with wrap", 24'h000180, 128);
    rd_chk("R6 neighbour page untouched", 24'h000200, 2);
  endtask

  task automatic t_discards();
    logic [7:0] v;
    cmd1(8'h04);
    cs_on(); send(8'h02); send(8'h00); send(8'h03); send(8'h00); send(8'h11); send(8'h22); cs_off();
    rdsr(v); chk("R7 write without enable dropped", v, 8'h84);
    cmd1(8'h06);
    cs_on(); send(8'h02); send(8'h00); send(8'h02); send(8'h00); send(8'h33);
    for (int i = 0; i < 3; i++) begin sck = 1'b0; si = 1'b1; tick(H); sck = 1'b1; tick(H); end
    cs_off();
    rdsr(v); chk("R7 off-boundary rise dropped", v, 8'h86);
    wr_deny = 1'b1;
    cs_on(); send(8'h02); send(8'h00); send(8'h02); send(8'h80); send(8'h44); cs_off();
    rdsr(v); chk("R7 denied page dropped", v, 8'h86);
    wr_deny = 1'b0;
    cmd1(8'h04);
    rd_chk("R7 dropped writes leave array", 24'h000300, 2);
    rd_chk("R7 dropped writes leave array", 24'h000200, 1);
    rd_chk("R7 dropped writes leave array", 24'h000280, 1);
  endtask

  task automatic t_read_wrap();
    rd_chk("R5 r4_ read wraps at top", 24'h7FFFFE, 4);
  endtask

  task automatic t_invalid();
    logic [7:0] r; bit o, any;
    any = 1'b0;
    cs_on(); send(8'h83);
    send(8'h03); send(8'h00); send(8'h00);
    xfer(8'h00, r, o); any |= o;
    xfer(8'h00, r, o); any |= o;
    chk("R3 locked after bad command", any, 1'b0);
    chk("R3 so floats while locked", so, 1'bz);
    cs_off();
    rd_chk("R3 next select recovers", 24'h000010, 1);
  endtask

  task automatic t_mode3();
    m3 = 1'b1;
    rd_chk("R2 mode 3 read", 24'h000123, 2);
    m3 = 1'b0;
  endtask

  task automatic t_hold();
    logic [7:0] r; bit o;
    cs_on(); send(8'h03); send(8'h00); send(8'h00); send(8'h40);
    xfer(8'h00, r, o); chk("R9 byte before hold", r, exp_m[12'h040]);
    sck = 1'b0; tick(H);
    hold_n = 1'b0; tick(H);
    chk("R9 so floats while held", so, 1'bz);
    for (int i = 0; i < 3; i++) begin si = ~si; sck = 1'b1; tick(H); sck = 1'b0; tick(H); end
    hold_n = 1'b1; tick(H);
    xfer(8'h00, r, o); chk("R9 resume continues", r, exp_m[12'h041]);
    xfer(8'h00, r, o); chk("R9 resume continues", r, exp_m[12'h042]);
    cs_off();
  endtask

  task automatic t_status_write();
    logic [7:0] v;
    int s0;
    s0 = stb_n;
    sr_deny = 1'b1;
    cmd1(8'h06);
    cs_on(); send(8'h01); send(8'h8C); cs_off();
    chk("R7 r12_ denied status write", stb_n, s0);
    rdsr(v); chk("R7 r12_ denied status not busy", v, 8'h86);
    sr_deny = 1'b0;
    cs_on(); send(8'h01); send(8'h8C); cs_off();
    chk("R12 status strobe count", stb_n, s0 + 1);
    chk("R12 status strobe data", stb_d, 8'h8C);
    rdsr(v); chk("R12 status write busy", v, 8'hFF);
    wait_ready();
    rdsr(v); chk("R12 enable cleared", v, 8'h84);
  endtask

  task automatic t_cs_high();
    for (int i = 0; i < 4; i++) begin si = ~si; sck = ~sck; tick(H); end
    sck = 1'b0; tick(H);
    chk("R10 so floats with select high", so, 1'bz);
  endtask

  initial begin
    for (int k = 0; k < MEMN; k++) begin
      mem[k]   = 8'(k * 5 + (k >> 8));
      exp_m[k] = 8'(k * 5 + (k >> 8));
    end
    tick(5);
    t_reset();
    rst_n = 1'b1; tick(5);
    t_status_wel();
    t_page_write();
    t_discards();
    t_read_wrap();
    t_invalid();
    t_mode3();
    t_hold();
    t_status_write();
    t_cs_high();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule